// File: doc/BRIEF.md
# Serial DAC Input Interface Controller

This block is the digital front end of a single-channel voltage DAC that is loaded over a three-wire serial link. The link has an active-low frame sync, a serial clock and a data line. All three are sampled by a system clock that runs at least four times faster than the serial clock. Each line passes through a two-flop synchronizer, and falling edges of the serial clock are found with an edge detector.

While the frame sync is low, every falling serial-clock edge shifts one data bit, MSB first, into a 24-bit shift register. When the 24th edge arrives, the frame is decoded into a 2-bit power mode and a data field. These values are then loaded into the DAC code register and the power-down register.

If the sync line rises before the 24th edge, the frame is dropped and nothing is written. After reset the code register holds either zero or midscale, chosen by a build-time parameter. It keeps that value until the first complete frame. A second parameter selects a 16-bit or 14-bit data field. The 14-bit field is left-justified in the same 24-bit frame.

Top module: `sdac_if_ctrl`

## Requirements
- R1: While the reset is asserted, and after it is released, the code output equals zero when RESET_MID is 0 and 1 followed by zeros (midscale) when RESET_MID is 1. The power mode output is 00. Both hold these values until the first complete frame.
- R2: A complete frame of 24 falling serial-clock edges with sync low loads the power mode from frame bits [17:16]. With DATA_W=16 it loads the code from bits [15:0].
- R3: Frame bits [23:18] have no effect on either output.
- R4: If sync rises before the 24th falling edge, including the case of a frame with no edges, the code and power mode keep their previous values.
- R5: Falling edges after the 24th, while sync stays low, are ignored. The outputs reflect only the first 24 bits.
- R6: Data is taken MSB first, one bit on each falling serial-clock edge. The first bit received becomes frame bit 23.
- R7: Serial-clock edges that occur while sync is high shift nothing. The next frame counts from its own first edge.
- R8: With DATA_W=14, the code is loaded from frame bits [15:2] and bits [1:0] are ignored.
- R9: All four power-mode values can be written: 00 normal, and 01, 10 and 11 for the three power-down loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_ni | input | 1 | Active-low frame sync (asynchronous) |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdin_i | input | 1 | Serial data, MSB first |
| dac_code_o | output | DATA_W | Parallel DAC code |
| pd_mode_o | output | 2 | Power mode select: 00 normal, others power-down loads |

## Verification
The assertions assume that the serial clock runs slowly enough for every level to be seen by at least two system-clock samples. They also assume that data is stable around each falling serial-clock edge. If either assumption is broken, edges can be missed or merged, and the bit counter no longer matches the frame. The stimulus keeps both high and low serial-clock phases four system cycles long. It changes data only while the serial clock is high, and it moves sync only while the serial clock is low. Two instances share the stimulus: one with a 16-bit field and zero reset, and one with a 14-bit field and midscale reset.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_W  = 24;
  localparam int MODE_LSB = 16;
  localparam int FIELD_W  = 16;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_LOAD_A = 2'b01,
    PM_LOAD_B = 2'b10,
    PM_LOAD_C = 2'b11
  } pmode_e;
endpackage

// File: rtl/sdac_rst_sync.sv
module sdac_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_no = out_q;
endmodule

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= RST_VAL[g];
        sync_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int LEN = FRAME_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_act_i,
  input  logic           sclk_i,
  input  logic           din_i,
  output logic [LEN-1:0] frame_o,
  output logic           done_o
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LEN);

  logic             sclk_d_q;
  logic             fall;
  logic             shift_en;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic [LEN-1:0]   sr_q,   sr_d;
  logic             done_q, done_d;

  assign fall     = sclk_d_q & ~sclk_i;
  assign shift_en = frame_act_i & fall & (cnt_q != CNT_FULL);

  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    done_d = 1'b0;
    if (!frame_act_i) begin
      cnt_d = '0;
    end else if (shift_en) begin
      cnt_d  = cnt_q + 1'b1;
      sr_d   = {sr_q[LEN-2:0], din_i};
      done_d = (cnt_q == CNT_LAST);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      sclk_d_q <= sclk_i;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
      if (shift_en) sr_q <= sr_d;
    end
  end

  assign frame_o = sr_q;
  assign done_o  = done_q;

  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act_i |=> (cnt_q == '0) && !done_q); // R7
  AST_DONE_NEEDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(frame_act_i)); // R4
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [DATA_W-1:0] code_o,
  output pmode_e            mode_o
);
  localparam int FIELD_HI = MODE_LSB - 1;

  logic [DATA_W-1:0] rst_code;
  logic [DATA_W-1:0] code_q, code_d;
  pmode_e            mode_q, mode_d;

  if (RESET_MID) begin : g_rst_mid
    assign rst_code = {1'b1, {(DATA_W-1){1'b0}}};
  end else begin : g_rst_zero
    assign rst_code = '0;
  end

  always_comb begin
    code_d = code_q;
    mode_d = mode_q;
    if (load_i) begin
      code_d = frame_i[FIELD_HI -: DATA_W];
      mode_d = pmode_e'(frame_i[MODE_LSB+1:MODE_LSB]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= rst_code;
      mode_q <= PM_NORMAL;
    end else if (load_i) begin
      code_q <= code_d;
      mode_q <= mode_d;
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_q) && $stable(mode_q)); // R4
  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> mode_q == pmode_e'($past(frame_i[MODE_LSB+1:MODE_LSB]))); // R2
endmodule

// File: rtl/sdac_if_ctrl.sv
module sdac_if_ctrl
  import sdac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [1:0]        pd_mode_o
);
  localparam int IN_W = 3;

  logic               rst_n;
  logic [IN_W-1:0]    pins_s;
  logic               frame_act;
  logic [FRAME_W-1:0] frame;
  logic               done;
  pmode_e             mode;

  sdac_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  sdac_sync #(.W(IN_W), .RST_VAL(3'b100)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i ({sync_ni, sclk_i, sdin_i}),
    .sync_o  (pins_s)
  );

  assign frame_act = ~pins_s[2];

  sdac_shift #(.LEN(FRAME_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .frame_act_i (frame_act),
    .sclk_i      (pins_s[1]),
    .din_i       (pins_s[0]),
    .frame_o     (frame),
    .done_o      (done)
  );

  sdac_regs #(.DATA_W(DATA_W), .RESET_MID(RESET_MID)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (done),
    .frame_i (frame),
    .code_o  (dac_code_o),
    .mode_o  (mode)
  );

  assign pd_mode_o = mode;

  AST_LOAD_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_n)
    done |-> frame_act); // R2
endmodule

// File: tb/sdac_if_ctrl_tb.sv
module sdac_if_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        sync_n;
  logic        sclk;
  logic        sdin;
  logic [15:0] code16;
  logic [1:0]  mode16;
  logic [13:0] code14;
  logic [1:0]  mode14;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] m_code16;
  logic [13:0] m_code14;
  logic [1:0]  m_mode;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sdac_if_ctrl #(.DATA_W(16), .RESET_MID(1'b0)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .sync_ni (sync_n), .sclk_i (sclk),
    .sdin_i (sdin), .dac_code_o (code16), .pd_mode_o (mode16)
  );

  sdac_if_ctrl #(.DATA_W(14), .RESET_MID(1'b1)) dut14_i (
    .clk_i (clk), .rst_ni (rst_n), .sync_ni (sync_n), .sclk_i (sclk),
    .sdin_i (sdin), .dac_code_o (code14), .pd_mode_o (mode14)
  );

  // {frame[23:0], falling edge count[5:0]}
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {24'h012345, 6'd24},
    {24'hFE8001, 6'd24},
    {24'h03FFFF, 6'd24},
    {24'h000000, 6'd24},
    {24'h025A5A, 6'd23},
    {24'h011111, 6'd5},
    {24'hFFC3C3, 6'd28},
    {24'h007FFE, 6'd24},
    {24'h031234, 6'd0},
    {24'hFD0003, 6'd24}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(logic [23:0] frm, int edges);
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < edges; i++) begin
      sclk = 1'b1;
      sdin = (i < 24) ? frm[23-i] : 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
    end
    sync_n = 1'b1;
    wait_clk(20);
    if (edges >= 24) begin
      m_code16 = frm[15:0];
      m_code14 = frm[15:2];
      m_mode   = frm[17:16];
    end
  endtask

  task automatic check_outputs(string tag);
    check({tag, " code16"}, 32'(code16), 32'(m_code16));
    check({tag, " code14"}, 32'(code14), 32'(m_code14));
    check({tag, " mode16"}, 32'(mode16), 32'(m_mode));
    check({tag, " mode14"}, 32'(mode14), 32'(m_mode));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    sync_n = 1'b1;
    sclk   = 1'b0;
    sdin   = 1'b0;
    m_code16 = 16'h0000;
    m_code14 = 14'h2000;
    m_mode   = 2'b00;
    wait_clk(4);
    check_outputs("R1 in reset");
    rst_n = 1'b1;
    wait_clk(6);
    check_outputs("R1 after release");

    // R4: sync pulse without edges right after reset keeps reset values
    send_frame(24'h02ABCD, 0);
    check_outputs("R1 R4 hold until first write");

    // R2 R3 R4 R5 R6 R8 R9: table walk
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][29:6], int'(VEC[v][5:0]));
      check_outputs($sformatf("R2 R3 R4 R5 R6 R8 R9 vec%0d", v));
    end

    // R7: clock edges with sync high shift nothing
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b1; sdin = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    wait_clk(10);
    check_outputs("R7 idle edges");
    send_frame(24'h01A5C3, 24);
    check_outputs("R7 fresh frame");

    // R4: abort one edge short, then a full frame
    send_frame(24'h036666, 23);
    check_outputs("R4 abort at 23");
    send_frame(24'h020F0F, 24);
    check_outputs("R2 after abort");

    // R1: reset mid-operation returns reset values
    rst_n = 1'b0;
    wait_clk(3);
    m_code16 = 16'h0000;
    m_code14 = 14'h2000;
    m_mode   = 2'b00;
    check_outputs("R1 re-reset");
    rst_n = 1'b1;
    wait_clk(6);
    check_outputs("R1 re-release");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule